// File: doc/BRIEF.md
# Central Bus Ownership Arbiter

This block decides which of several would-be bus masters owns a shared bus next. The masters may be the processor and any number of direct-memory-access engines. Each master has its own request input and its own grant output. All masters share a single busy line, formed outside the block as the OR of every current owner's busy signal. The arbiter only hands out a grant while that line is low. It never assumes that a handover has happened. It waits until the granted master shows that it has taken the bus by raising busy.

When several requests are pending, the winner is chosen in round-robin order. The search starts at the index just after the most recent grant. A grant stays up until the chosen master raises busy, and it is dropped on the following cycle. If the master lowers its request first, or never raises busy within a fixed number of cycles, the grant is withdrawn and arbitration runs again. There is no data stream through the block. All pins are plain level-sensitive control signals, with no valid/ready handshake and no back-pressure.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after its release, `gnt_o` is all zeros, whatever `req_i` and `busy_i` are doing.
- R2: At most one bit of `gnt_o` is set in any cycle. Bit i of `gnt_o` corresponds to bit i of `req_i`.
- R3: A new grant first appears on the cycle after a clock edge at which `busy_i` was low and at least one request was high. No grant is issued while `busy_i` stays high.
- R4: An outstanding grant stays asserted until `busy_i` is sampled high. It is deasserted on the next cycle, and no further grant is issued until `busy_i` is sampled low again.
- R5: Among pending requests, the winner is the first index with a request in the order last+1, last+2, and so on, wrapping modulo N_REQ. Here "last" is the most recently granted index. After reset, index 0 has the top position.
- R6: If `busy_i` stays low for GRANT_TIMEOUT cycles while a grant is up, the grant is removed on the next cycle. A new round-robin arbitration then starts one cycle later, and the withdrawn index counts as the last grant.
- R7: If the granted requester lowers its request before `busy_i` rises, the grant is removed on the next cycle. A request that is lowered before it wins is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | Per-master bus request, held high while the master wants the bus |
| busy_i | input | 1 | Shared bus-busy line, the OR of every current owner's busy signal |
| gnt_o | output | N_REQ | One-hot grant to the chosen next owner |

## Verification
The bound checker watches four properties on every cycle. It checks that the grant vector is one-hot or zero, and that every fresh grant follows an edge where busy was low and the granted master was requesting. It also checks that a grant seen together with busy, or with its request missing, is gone on the next cycle, and that no grant stays up longer than the timeout window. Only the directed scenarios show which master wins, so the bench must cover the round-robin order with wrap-around, the choice of the next index after a timeout, and the fact that a request lowered while busy was high never receives a grant.

// File: rtl/bus_grant_arbiter_pkg.sv
package bus_grant_arbiter_pkg;
  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_OFFER = 1'b1
  } arb_state_t;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] cand [N_REQ];
  logic [N_REQ-1:0] hit;

  for (genvar o = 0; o < N_REQ; o++) begin : g_cand
    assign cand[o] = IDX_W'((int'(last_i) + o + 1) % N_REQ);
    assign hit[o]  = req_i[cand[o]];
  end

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int o = 0; o < N_REQ; o++) begin
      if (!vld_o && hit[o]) begin
        vld_o = 1'b1;
        idx_o = cand[o];
      end
    end
  end
endmodule

// File: rtl/offer_timer.sv
module offer_timer #(
  parameter int GRANT_TIMEOUT = 8,
  localparam int TW = $clog2(GRANT_TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == TW'(GRANT_TIMEOUT - 1));
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
  import bus_grant_arbiter_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int GRANT_TIMEOUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic             busy_i,
  output logic [N_REQ-1:0] gnt_o
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  arb_state_t       state_q, state_d;
  logic [IDX_W-1:0] owner_q, last_q;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_vld, issue, expired, owner_req;

  rr_pick #(.N_REQ(N_REQ)) u_pick (
    .req_i (req_i),
    .last_i(last_q),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  offer_timer #(.GRANT_TIMEOUT(GRANT_TIMEOUT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (issue),
    .run_i    (state_q == ARB_OFFER),
    .expired_o(expired)
  );

  assign owner_req = req_i[owner_q];

  always_comb begin
    state_d = state_q;
    issue   = 1'b0;
    case (state_q)
      ARB_IDLE: begin
        if (!busy_i && pick_vld) begin
          state_d = ARB_OFFER;
          issue   = 1'b1;
        end
      end
      ARB_OFFER: begin
        // ownership taken, request withdrawn, or timeout: offer ends
        if (busy_i || !owner_req || expired) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      owner_q <= '0;
      last_q  <= IDX_W'(N_REQ - 1);
    end else begin
      state_q <= state_d;
      if (issue) begin
        owner_q <= pick_idx;
        last_q  <= pick_idx;
      end
    end
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_gnt
    assign gnt_o[i] = (state_q == ARB_OFFER) && (owner_q == IDX_W'(i));
  end
endmodule

// File: rtl/bus_grant_arbiter_chk.sv
module bus_grant_arbiter_chk #(
  parameter int N_REQ = 4,
  parameter int GRANT_TIMEOUT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req_i,
  input logic             busy_i,
  input logic [N_REQ-1:0] gnt_o
);
  localparam int HW = $clog2(GRANT_TIMEOUT + 2);
  logic [HW-1:0] held_q;
  logic          any_gnt;

  assign any_gnt = |gnt_o;

  always_ff @(posedge clk) begin
    if (!rst_n || !any_gnt) held_q <= '0;
    else if (held_q != HW'(GRANT_TIMEOUT + 1)) held_q <= held_q + 1'b1;
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && !$past(any_gnt)) |-> (!$past(busy_i) && |(gnt_o & $past(req_i))));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && busy_i) |=> !any_gnt);

  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_gnt |-> (held_q < HW'(GRANT_TIMEOUT)));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && !busy_i && !(|(gnt_o & req_i))) |=> !any_gnt);
endmodule

bind bus_grant_arbiter bus_grant_arbiter_chk #(
  .N_REQ(N_REQ),
  .GRANT_TIMEOUT(GRANT_TIMEOUT)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req_i (req_i),
  .busy_i(busy_i),
  .gnt_o (gnt_o)
);

// File: tb/bus_grant_arbiter_bench.sv
`timescale 1ns/1ps
module bus_grant_arbiter_bench;
  localparam int N  = 4;
  localparam int TO = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         busy;
  logic [N-1:0] gnt;
  int           n_chk = 0;
  int           n_bad = 0;
  int           last_seen;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  bus_grant_arbiter #(.N_REQ(N), .GRANT_TIMEOUT(TO)) u_bus_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .busy_i(busy), .gnt_o(gnt)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [N-1:0] exp);
    n_chk++;
    if (gnt !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt_o actual %b expected %b", tag, gnt, exp);
    end
  endtask

  function automatic logic [N-1:0] oh(input int i);
    return N'(1) << i;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = '1; busy = 1'b0;
    repeat (3) tick();
    check("R1 during reset", '0);
    rst_n = 1'b1; req = '0;
    tick();
    check("R1 after release", '0);
    last_seen = N - 1;
  endtask

  task automatic t_single();
    req = 4'b0100;
    tick(); check("R3 grant on idle bus", 4'b0100); last_seen = 2;
    busy = 1'b1;
    tick(); check("R4 grant dropped after busy", '0);
    repeat (3) tick();
    check("R4 no grant while owner busy", '0);
    req = '0; busy = 1'b0;
    tick(); check("R3 no request no grant", '0);
  endtask

  task automatic t_busy_block();
    busy = 1'b1; req = 4'b0010;
    repeat (4) tick();
    check("R3 held back while busy", '0);
    busy = 1'b0;
    tick(); check("R3 grant after busy low", 4'b0010); last_seen = 1;
    busy = 1'b1;
    tick(); check("R4 taken", '0);
    req = '0; busy = 1'b0;
    tick(); check("R4 idle after release", '0);
  endtask

  task automatic t_rr();
    req = '1;
    tick();
    for (int k = 0; k < N; k++) begin
      int e;
      e = (last_seen + 1) % N;
      check("R5 round-robin order", oh(e));
      n_chk++;
      if ($countones(gnt) > 1) begin
        n_bad++;
        $display("FAIL R2: gnt_o actual %b expected one-hot", gnt);
      end
      last_seen = e;
      busy = 1'b1;
      tick(); check("R4 drop on ownership", '0);
      busy = 1'b0;
      if (k == N - 1) req = '0;
      tick();
    end
    check("R5 no grant after requests end", '0);
  endtask

  task automatic t_timeout();
    req = 4'b1001;
    tick(); check("R6 first pick", oh((last_seen + 1) % N == 1 ? 3 : 3));
    last_seen = 3;
    repeat (TO - 1) tick();
    check("R6 still held inside window", 4'b1000);
    tick(); check("R6 withdrawn at timeout", '0);
    tick(); check("R6 rearbitration picks next", 4'b0001);
    last_seen = 0;
    busy = 1'b1;
    tick(); check("R4 taken after timeout", '0);
    req = '0; busy = 1'b0;
    tick(); check("R4 idle", '0);
  endtask

  task automatic t_drop();
    req = 4'b0100;
    tick(); check("R7 granted", 4'b0100); last_seen = 2;
    req = '0;
    tick(); check("R7 grant removed on drop", '0);
    busy = 1'b1; req = 4'b1010;
    tick();
    req = 4'b0010;
    tick();
    busy = 1'b0;
    tick(); check("R7 dropped requester skipped", 4'b0010); last_seen = 1;
    busy = 1'b1;
    tick(); check("R4 taken", '0);
    req = '0; busy = 1'b0;
    tick(); check("R7 idle at end", '0);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_single();
    t_busy_block();
    t_rr();
    t_timeout();
    t_drop();
    report();
  end
endmodule